// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Address Front End

This block is the front end of a two-wire serial memory slave. It receives SCL and SDA from the bus, brings both onto a faster system clock and finds start and stop conditions. After a start it shifts in the device byte and checks it against a fixed prefix and one strap input. When the byte matches, the block pulls SDA low through an open-drain enable for the acknowledge clock.

For a write, two more address bytes follow. Each is acknowledged. The page bit from the device byte is joined with the high and low bytes into a 17-bit word address. A one-cycle strobe then hands the address and direction to downstream logic. For a read, the strobe fires as soon as the device byte matches. Only the address top bit is updated then, because downstream logic owns the rest of a current-address read.

Data storage, the write timer and read data shifting belong to other blocks. After the address phase the front end stays quiet until the next start or stop.

Top module: `eaf_addr_front`

## Requirements
- R1: After reset, `sda_drive_low`, `txn_valid`, `dir_read` and `word_addr` are all 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, bits clocked without a new start are never acknowledged.
- R3: The device byte is taken MSB first. Its bits 7..3 must equal 1,0,1,0,0. Otherwise the block does not acknowledge, and it ignores every further byte until the next start.
- R4: Bit 2 of the device byte must equal `strap_sel`. A mismatch behaves as in R3.
- R5: Bit 1 of the device byte becomes `word_addr[16]`.
- R6: Bit 0 of the device byte gives the direction: 1 is read (`dir_read`=1) and 0 is write. `dir_read` changes only in a cycle where `txn_valid` is 1.
- R7: On a match, `sda_drive_low` rises only while SCL is low, after the eighth bit. It falls at the next SCL falling edge, so SDA reads low during the whole high phase of the acknowledge clock.
- R8: For a write, a high then a low address byte follow, and each is acknowledged. `word_addr` becomes {page, high, low}. `txn_valid` is high for exactly one cycle, at the start of the low-byte acknowledge.
- R9: For a read, `txn_valid` pulses once at the start of the device-byte acknowledge. `word_addr[15:0]` keeps its previous value, and `word_addr` changes only when `txn_valid` is 1.
- R10: A start or stop in the middle of a byte aborts the transfer and clears the bit count. A start begins a new device byte, and an aborted transfer produces no strobe.
- R11: After the low-byte acknowledge of a write, further bytes are not acknowledged and raise no strobe until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| strap_sel | input | 1 | Hardwired device-select strap |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| word_addr | output | 17 | Captured word address |
| dir_read | output | 1 | 1 for read, 0 for write |
| txn_valid | output | 1 | One-cycle strobe: address and direction are new |

## Verification
The assertions assume the following about the inputs:
- SCL and SDA are slow relative to `clk`, so each level lasts many cycles after synchronization.
- SDA changes only while SCL is low, except where the master deliberately makes a start or a stop.
- Start and stop therefore never coincide with an SCL edge.

The bench master holds every SCL phase for eight system cycles. It changes SDA four cycles into the low phase, and it makes starts and stops only with SCL held high. Aborts happen only from the SCL-low point between bits.

// File: rtl/eaf_pkg.sv
// Shared constants and state type for the two-wire address front end.
// Assumes 8-bit bus bytes and a 17-bit word address (page bit + two bytes).
package eaf_pkg;
    localparam int BYTE_W    = 8;
    localparam int PREFIX_W  = 5;
    localparam int WADDR_W   = 2 * BYTE_W + 1;
    localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b10100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_ADR_HI,
        ST_ACK_HI,
        ST_ADR_LO,
        ST_ACK_LO,
        ST_HOLD
    } eaf_state_e;
endpackage

// File: rtl/eaf_line_sync.sv
// Synchronizes SCL/SDA and flags SCL edges plus start/stop conditions.
// Assumes both lines idle high and SYNC_STAGES >= 2.
module eaf_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains and one-cycle history of the settled levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_level = scl_pipe[SYNC_STAGES-1];
    assign sda_level = sda_pipe[SYNC_STAGES-1];

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_level & ~scl_prev;
        scl_fall  = ~scl_level & scl_prev;
        start_det = scl_level & scl_prev & sda_prev & ~sda_level;
        stop_det  = scl_level & scl_prev & ~sda_prev & sda_level;
    end
endmodule

// File: rtl/eaf_byte_rx.sv
// MSB-first byte shifter with bit counter; samples on SCL rising edges.
// Assumes the controller clears it between bytes and gates it with en.
module eaf_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              sample,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] data,
    output logic              full
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] bit_cnt;

    assign full = (bit_cnt == CNT_W'(BYTE_W));

    // Shift one bit per sampling edge until the byte is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            data    <= '0;
        end else if (clr) begin
            bit_cnt <= '0;
        end else if (en && sample && !full) begin
            data    <= {data[BYTE_W-2:0], bit_in};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eaf_ctrl.sv
// Address-phase sequencer: matches the device byte, drives acknowledges,
// assembles the word address and strobes it out.
// Assumes byte_full/rx_byte come from eaf_byte_rx; acts on SCL falling edges.
module eaf_ctrl
    import eaf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               scl_fall,
    input  logic               byte_full,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               strap_sel,
    output logic               rx_en,
    output logic               rx_clr,
    output logic               sda_drive_low,
    output logic [WADDR_W-1:0] word_addr,
    output logic               dir_read,
    output logic               txn_valid
);
    eaf_state_e        state;
    logic              page_bit;
    logic              rd_pend;
    logic [BYTE_W-1:0] hi_byte;
    logic              dev_match;

    // Device byte decode: fixed prefix plus strap bit.
    always_comb begin
        dev_match = (rx_byte[BYTE_W-1 -: PREFIX_W] == DEV_PREFIX)
                 && (rx_byte[2] == strap_sel);
    end

    // Shifter control: enable in byte states, clear on conditions and byte end.
    always_comb begin
        rx_en  = (state == ST_DEV) || (state == ST_ADR_HI) || (state == ST_ADR_LO);
        rx_clr = start_det | stop_det | (scl_fall & byte_full);
    end

    // Main sequencer and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            page_bit      <= 1'b0;
            rd_pend       <= 1'b0;
            hi_byte       <= '0;
            sda_drive_low <= 1'b0;
            word_addr     <= '0;
            dir_read      <= 1'b0;
            txn_valid     <= 1'b0;
        end else begin
            txn_valid <= 1'b0;
            if (start_det) begin
                state         <= ST_DEV;
                sda_drive_low <= 1'b0;
            end else if (stop_det) begin
                state         <= ST_IDLE;
                sda_drive_low <= 1'b0;
            end else if (scl_fall) begin
                case (state)
                    ST_DEV: if (byte_full) begin
                        if (dev_match) begin
                            sda_drive_low <= 1'b1;
                            page_bit      <= rx_byte[1];
                            rd_pend       <= rx_byte[0];
                            state         <= ST_ACK_DEV;
                            if (rx_byte[0]) begin
                                word_addr[WADDR_W-1] <= rx_byte[1];
                                dir_read             <= 1'b1;
                                txn_valid            <= 1'b1;
                            end
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_ACK_DEV: begin
                        sda_drive_low <= 1'b0;
                        state         <= rd_pend ? ST_HOLD : ST_ADR_HI;
                    end
                    ST_ADR_HI: if (byte_full) begin
                        hi_byte       <= rx_byte;
                        sda_drive_low <= 1'b1;
                        state         <= ST_ACK_HI;
                    end
                    ST_ACK_HI: begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_ADR_LO;
                    end
                    ST_ADR_LO: if (byte_full) begin
                        word_addr     <= {page_bit, hi_byte, rx_byte};
                        dir_read      <= 1'b0;
                        txn_valid     <= 1'b1;
                        sda_drive_low <= 1'b1;
                        state         <= ST_ACK_LO;
                    end
                    ST_ACK_LO: begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eaf_addr_front.sv
// Top of the two-wire memory slave address front end.
// Assumes SCL/SDA are far slower than clk; SDA output is open-drain enable only.
module eaf_addr_front
    import eaf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               strap_sel,
    output logic               sda_drive_low,
    output logic [WADDR_W-1:0] word_addr,
    output logic               dir_read,
    output logic               txn_valid
);
    logic              scl_level;
    logic              sda_level;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              rx_en;
    logic              rx_clr;
    logic              byte_full;
    logic [BYTE_W-1:0] rx_byte;

    eaf_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_level (scl_level),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eaf_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .en     (rx_en),
        .sample (scl_rise),
        .bit_in (sda_level),
        .data   (rx_byte),
        .full   (byte_full)
    );

    eaf_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .scl_fall      (scl_fall),
        .byte_full     (byte_full),
        .rx_byte       (rx_byte),
        .strap_sel     (strap_sel),
        .rx_en         (rx_en),
        .rx_clr        (rx_clr),
        .sda_drive_low (sda_drive_low),
        .word_addr     (word_addr),
        .dir_read      (dir_read),
        .txn_valid     (txn_valid)
    );
endmodule

// File: rtl/eaf_checker.sv
// Protocol checks for eaf_addr_front, attached with bind.
// Assumes bus conditions never coincide with SCL edges.
module eaf_checker #(
    parameter int WADDR_W = 17
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_level,
    input logic               start_det,
    input logic               stop_det,
    input logic               sda_drive_low,
    input logic [WADDR_W-1:0] word_addr,
    input logic               dir_read,
    input logic               txn_valid
);
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low); // R2
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_low); // R10
    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_level); // R7
    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_drive_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_level); // R7
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid); // R8
    AST_ADDR_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_addr) |-> txn_valid); // R9
    AST_DIR_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_read) |-> txn_valid); // R6
endmodule

bind eaf_addr_front eaf_checker #(.WADDR_W(eaf_pkg::WADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_level     (scl_level),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .word_addr     (word_addr),
    .dir_read      (dir_read),
    .txn_valid     (txn_valid)
);

// File: tb/eaf_addr_front_bench.sv
module eaf_addr_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        strap = 1'b0;
    logic        bus_sda;
    logic        drive;
    logic [16:0] word_addr;
    logic        dir_read;
    logic        txn_valid;

    int          n_chk = 0;
    int          n_fail = 0;
    int          vcnt = 0;
    logic [16:0] cap_addr = '0;
    logic        cap_dir = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign bus_sda = m_sda & ~drive;

    eaf_addr_front u_eaf_addr_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (bus_sda),
        .strap_sel     (strap),
        .sda_drive_low (drive),
        .word_addr     (word_addr),
        .dir_read      (dir_read),
        .txn_valid     (txn_valid)
    );

    // Strobe monitor at the ports.
    always @(negedge clk) begin
        if (rst_n && txn_valid) begin
            vcnt     = vcnt + 1;
            cap_addr = word_addr;
            cap_dir  = dir_read;
        end
    end

    typedef struct packed {
        logic        strap;
        logic [7:0]  dev;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic        ack;
        logic [16:0] addr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'hA0, 8'h12, 8'h34, 1'b1, 17'h01234},
        '{1'b0, 8'hA2, 8'hFF, 8'h00, 1'b1, 17'h1FF00},
        '{1'b1, 8'hA6, 8'h5A, 8'hA5, 1'b1, 17'h15AA5},
        '{1'b1, 8'hA0, 8'h11, 8'h22, 1'b0, 17'h15AA5},
        '{1'b0, 8'hB0, 8'h11, 8'h22, 1'b0, 17'h15AA5},
        '{1'b0, 8'hA3, 8'h00, 8'h00, 1'b1, 17'h15AA5},
        '{1'b1, 8'hA5, 8'h00, 8'h00, 1'b1, 17'h05AA5},
        '{1'b0, 8'h20, 8'h11, 8'h22, 1'b0, 17'h05AA5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; cyc(4);
        m_scl = 1'b1; cyc(8);
        m_scl = 1'b0; cyc(4);
    endtask

    task automatic get_ack(output logic a);
        m_sda = 1'b1; cyc(4);
        m_scl = 1'b1; cyc(4);
        a = ~bus_sda; cyc(4);
        m_scl = 1'b0; cyc(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_ack(a);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; cyc(4);
        m_scl = 1'b1; cyc(4);
        m_sda = 1'b0; cyc(4);
        m_scl = 1'b0; cyc(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; cyc(4);
        m_scl = 1'b1; cyc(4);
        m_sda = 1'b1; cyc(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        int   v0;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        chk("R1 drive", drive, 0);
        chk("R1 valid", txn_valid, 0);
        chk("R1 addr", word_addr, 0);
        chk("R1 dir", dir_read, 0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            strap = v.strap;
            cyc(4);
            bus_start();
            v0 = vcnt;
            send_byte(v.dev, a);
            chk("R3/R4 device ack", a, v.ack);
            chk("R7 ack released", drive, 0);
            if (!v.dev[0]) begin
                send_byte(v.hi, a);
                chk("R8 high ack", a, v.ack);
                send_byte(v.lo, a);
                chk("R8 low ack", a, v.ack);
            end
            bus_stop();
            chk("R8/R9 strobe count", vcnt - v0, v.ack);
            chk("R5/R9 word address", word_addr, v.addr);
            if (v.ack) chk("R6 direction", cap_dir, v.dev[0]);
        end

        // R2: after a stop, a byte without start is ignored
        v0 = vcnt;
        send_byte(8'hA0, a);
        chk("R2 no ack without start", a, 0);
        chk("R2 no strobe", vcnt - v0, 0);

        // R10: start in mid-byte restarts the device byte
        strap = 1'b0;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        v0 = vcnt;
        send_byte(8'hA0, a);
        chk("R10 ack after restart", a, 1);
        send_byte(8'h07, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R10 strobe after restart", vcnt - v0, 1);
        chk("R10 address after restart", cap_addr, 17'h00777);

        // R10: stop in mid-address aborts with no strobe
        bus_start();
        v0 = vcnt;
        send_byte(8'hA0, a);
        send_byte(8'h11, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R10 aborted no strobe", vcnt - v0, 0);
        chk("R10 aborted address kept", word_addr, 17'h00777);

        // R11: bytes after the address phase are not acknowledged
        bus_start();
        v0 = vcnt;
        send_byte(8'hA2, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        chk("R8 low ack", a, 1);
        send_byte(8'h44, a);
        chk("R11 extra byte no ack", a, 0);
        send_byte(8'hA0, a);
        chk("R11 second extra no ack", a, 0);
        bus_stop();
        chk("R11 single strobe", vcnt - v0, 1);
        chk("R5 address with page", word_addr, 17'h12233);
        chk("R6 write direction", dir_read, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule